// File: doc/BRIEF.md
# Wait-for-event sleep controller

This block sits beside a processor core and decides what happens when the core asks to wait for an event. It keeps a single pending-event flag. Three sources can raise the flag, each with a one-cycle pulse: a software send-event, entry into an interrupt, and a debug event. The flag saturates at 1, so any number of events before a wait collapse into one pending wake.

When the core pulses a wait request, one of two things happens. If an event is pending, or one arrives in that same cycle, the block consumes it and reports completion at once. Otherwise it enters a low-power state. It stays there until any event source fires, and then wakes the core and reports completion. The flag is visible on an output for observation. Clock gating, interrupt arbitration and instruction decoding belong to other blocks.

Top module: `wfe_sleep_ctrl`

## Requirements
- R1: A one-cycle pulse on `send_evt`, `irq_entry` or `dbg_evt` while awake and without a wait request makes `evt_flag` read 1 from the cycle after the pulse.
- R2: Several event pulses before a wait leave `evt_flag` at 1. A single wait request then consumes them all, and a second wait request with no new event puts the block to sleep.
- R3: A wait request that finds `evt_flag` at 1 clears it to 0 and raises `wait_done` in the cycle after the request. `sleeping` stays 0.
- R4: A wait request that finds `evt_flag` at 0, with no event in the same cycle, sets `sleeping` to 1 from the next cycle and raises no `wait_done`.
- R5: While `sleeping` is 1, a pulse on any of the three event sources clears `sleeping` and raises `wait_done` in the next cycle.
- R6: The event that wakes the block is consumed, so `evt_flag` reads 0 after wake-up.
- R7: An event pulse in the same cycle as a wait request counts as already pending. The wait completes without sleeping, with `wait_done` 1 and `evt_flag` 0 in the next cycle.
- R8: `wait_done` is high for exactly one cycle per completed wait.
- R9: Wait requests that arrive while `sleeping` is 1 are ignored. The block stays asleep, `wait_done` stays 0 and `evt_flag` stays 0.
- R10: With no event and no wait request, `evt_flag` keeps its value.
- R11: While `rst_n` is low at a clock edge, the next cycle shows `evt_flag` 0, `sleeping` 0 and `wait_done` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wait_req | input | 1 | One-cycle pulse: core asks to wait for an event |
| send_evt | input | 1 | One-cycle pulse: software send-event |
| irq_entry | input | 1 | One-cycle pulse: interrupt entry |
| dbg_evt | input | 1 | One-cycle pulse: debug event |
| sleeping | output | 1 | Block is in the low-power state |
| wait_done | output | 1 | One-cycle pulse: a wait request has completed |
| evt_flag | output | 1 | Current pending-event flag |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle of the wait request. That is the check-then-sleep race, and a late event there could be lost. The bench drives both pulses in the same low clock phase, so they are sampled by one edge, and then checks that the block never sleeps. A second hard case is a wait request arriving while already asleep. The bench reaches it by first sleeping with the flag clear, then pulsing the wait again, and then waking with each event source in turn.

// File: rtl/wfe_pkg.sv
package wfe_pkg;
   typedef enum logic {
      ST_AWAKE  = 1'b0,
      ST_ASLEEP = 1'b1
   } wfe_state_e;

   localparam int unsigned SRC_SEND  = 0;
   localparam int unsigned SRC_IRQ   = 1;
   localparam int unsigned SRC_DEBUG = 2;
   localparam int unsigned SRC_COUNT = 3;
endpackage

// File: rtl/wfe_evt_merge.sv
module wfe_evt_merge #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic [NUM_SRC-1:0] src_pulse,
   output logic               any_evt
);
   localparam int unsigned LAST = NUM_SRC - 1;

   logic [NUM_SRC-1:0] chain;

   generate
      if (NUM_SRC < 1) begin : g_bad
         $error("wfe_evt_merge: NUM_SRC must be at least 1");
      end
      genvar i;
      for (i = 0; i < NUM_SRC; i++) begin : g_or
         if (i == 0) begin : g_first
            assign chain[i] = src_pulse[i];
         end else begin : g_next
            assign chain[i] = chain[i-1] | src_pulse[i];
         end
      end
   endgenerate

   assign any_evt = chain[LAST];
endmodule

// File: rtl/wfe_flag.sv
module wfe_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic consume_i,
   output logic flag_o
);
   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (consume_i) begin
         flag_d = 1'b0;
      end else if (set_i) begin
         flag_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= flag_d;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/wfe_sleep_fsm.sv
module wfe_sleep_fsm
   import wfe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wait_i,
   input  logic evt_i,
   input  logic flag_i,
   output logic consume_o,
   output logic sleeping_o,
   output logic done_o
);
   wfe_state_e state_q, state_d;
   logic       done_q, done_d;
   logic       pending;

   assign pending = flag_i | evt_i;

   always_comb begin
      state_d   = state_q;
      done_d    = 1'b0;
      consume_o = 1'b0;
      unique case (state_q)
         ST_AWAKE: begin
            if (wait_i) begin
               if (pending) begin
                  consume_o = 1'b1;
                  done_d    = 1'b1;
               end else begin
                  state_d = ST_ASLEEP;
               end
            end
         end
         ST_ASLEEP: begin
            if (evt_i) begin
               consume_o = 1'b1;
               done_d    = 1'b1;
               state_d   = ST_AWAKE;
            end
         end
         default: state_d = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end

   assign sleeping_o = (state_q == ST_ASLEEP);
   assign done_o     = done_q;
endmodule

// File: rtl/wfe_sleep_ctrl.sv
module wfe_sleep_ctrl
   import wfe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wait_req,
   input  logic send_evt,
   input  logic irq_entry,
   input  logic dbg_evt,
   output logic sleeping,
   output logic wait_done,
   output logic evt_flag
);
   localparam int unsigned NSRC = SRC_COUNT;

   logic [NSRC-1:0] src_vec;
   logic            any_evt;
   logic            consume;
   logic            flag;

   always_comb begin
      src_vec            = '0;
      src_vec[SRC_SEND]  = send_evt;
      src_vec[SRC_IRQ]   = irq_entry;
      src_vec[SRC_DEBUG] = dbg_evt;
   end

   wfe_evt_merge #(.NUM_SRC(NSRC)) u_merge (
      .src_pulse (src_vec),
      .any_evt   (any_evt)
   );

   wfe_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (any_evt),
      .consume_i (consume),
      .flag_o    (flag)
   );

   wfe_sleep_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_i     (wait_req),
      .evt_i      (any_evt),
      .flag_i     (flag),
      .consume_o  (consume),
      .sleeping_o (sleeping),
      .done_o     (wait_done)
   );

   assign evt_flag = flag;
endmodule

// File: rtl/wfe_sleep_ctrl_chk.sv
module wfe_sleep_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic wait_req,
   input logic send_evt,
   input logic irq_entry,
   input logic dbg_evt,
   input logic sleeping,
   input logic wait_done,
   input logic evt_flag
);
   logic ev;
   assign ev = send_evt | irq_entry | dbg_evt;

   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && !wait_req && ev) |=> evt_flag); // R1

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && !wait_req && !ev) |=> (evt_flag == $past(evt_flag))); // R10

   AST_PENDING_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && wait_req && evt_flag) |=> (!evt_flag && wait_done && !sleeping)); // R3

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && wait_req && !evt_flag && !ev) |=> (sleeping && !wait_done)); // R4

   AST_WAKE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && ev) |=> (!sleeping && wait_done)); // R5

   AST_WAKE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && ev) |=> !evt_flag); // R6

   AST_RACE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && wait_req && ev) |=> (!sleeping && wait_done && !evt_flag)); // R7

   AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_done |-> ($past(wait_req) || $past(sleeping))); // R8

   AST_ASLEEP_IGNORES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && !ev) |=> (sleeping && !wait_done && !evt_flag)); // R9

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (!evt_flag && !sleeping && !wait_done)); // R11
endmodule

bind wfe_sleep_ctrl wfe_sleep_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wait_req  (wait_req),
   .send_evt  (send_evt),
   .irq_entry (irq_entry),
   .dbg_evt   (dbg_evt),
   .sleeping  (sleeping),
   .wait_done (wait_done),
   .evt_flag  (evt_flag)
);

// File: tb/wfe_sleep_ctrl_bench.sv
module wfe_sleep_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wait_req = 1'b0;
   logic send_evt = 1'b0;
   logic irq_entry = 1'b0;
   logic dbg_evt = 1'b0;
   logic sleeping, wait_done, evt_flag;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wfe_sleep_ctrl u_wfe_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .send_evt(send_evt),
      .irq_entry(irq_entry), .dbg_evt(dbg_evt),
      .sleeping(sleeping), .wait_done(wait_done), .evt_flag(evt_flag)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Drive one cycle of inputs in the low phase; returns at the next falling edge.
   task automatic step(input logic w, input logic s, input logic i, input logic d);
      wait_req = w; send_evt = s; irq_entry = i; dbg_evt = d;
      @(negedge clk);
      wait_req = 0; send_evt = 0; irq_entry = 0; dbg_evt = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      step(0, 1, 0, 0);
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      rst_n = 1'b0;
      step(0, 0, 0, 0);
      chk("R11", "flag after reset", evt_flag, 1'b0);
      chk("R11", "sleeping after reset", sleeping, 1'b0);
      chk("R11", "done after reset", wait_done, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_each_source();
      for (int k = 0; k < 3; k++) begin
         do_reset();
         step(0, k == 0, k == 1, k == 2);
         chk("R1", $sformatf("flag set by source %0d", k), evt_flag, 1'b1);
         step(0, 0, 0, 0);
         step(0, 0, 0, 0);
         chk("R10", "flag held while idle", evt_flag, 1'b1);
      end
   endtask

   task automatic t_saturate();
      do_reset();
      step(0, 1, 0, 0);
      step(0, 0, 1, 0);
      step(0, 1, 0, 1);
      chk("R2", "flag saturated", evt_flag, 1'b1);
      step(1, 0, 0, 0);
      chk("R3", "wait consumed flag", evt_flag, 1'b0);
      chk("R3", "wait done immediate", wait_done, 1'b1);
      chk("R3", "no sleep on pending", sleeping, 1'b0);
      step(0, 0, 0, 0);
      chk("R8", "done one cycle", wait_done, 1'b0);
      step(1, 0, 0, 0);
      chk("R2", "second wait sleeps", sleeping, 1'b1);
      chk("R4", "no done on sleep entry", wait_done, 1'b0);
      step(0, 1, 0, 0);
      chk("R5", "woken", sleeping, 1'b0);
   endtask

   task automatic t_sleep_wake();
      for (int k = 0; k < 3; k++) begin
         do_reset();
         step(0, 0, 0, 0);
         chk("R10", "idle flag stays 0", evt_flag, 1'b0);
         step(1, 0, 0, 0);
         chk("R4", "asleep", sleeping, 1'b1);
         step(0, 0, 0, 0);
         chk("R4", "still asleep", sleeping, 1'b1);
         step(1, 0, 0, 0);
         chk("R9", "wait while asleep: sleeping", sleeping, 1'b1);
         chk("R9", "wait while asleep: done", wait_done, 1'b0);
         chk("R9", "wait while asleep: flag", evt_flag, 1'b0);
         step(0, k == 0, k == 1, k == 2);
         chk("R5", $sformatf("awake after source %0d", k), sleeping, 1'b0);
         chk("R5", "wake done", wait_done, 1'b1);
         chk("R6", "flag consumed on wake", evt_flag, 1'b0);
         step(0, 0, 0, 0);
         chk("R8", "wake done one cycle", wait_done, 1'b0);
         chk("R6", "flag stays 0 after wake", evt_flag, 1'b0);
      end
   endtask

   task automatic t_race();
      do_reset();
      step(1, 0, 1, 0);
      chk("R7", "race no sleep", sleeping, 1'b0);
      chk("R7", "race done", wait_done, 1'b1);
      chk("R7", "race flag cleared", evt_flag, 1'b0);
      step(1, 1, 0, 0);
      chk("R7", "back-to-back race done", wait_done, 1'b1);
      chk("R7", "back-to-back race no sleep", sleeping, 1'b0);
      step(0, 0, 0, 0);
      chk("R8", "done drops", wait_done, 1'b0);
   endtask

   initial begin
      do_reset();
      chk("R11", "initial flag", evt_flag, 1'b0);
      chk("R11", "initial sleeping", sleeping, 1'b0);
      chk("R11", "initial done", wait_done, 1'b0);
      t_reset();
      t_each_source();
      t_saturate();
      t_sleep_wake();
      t_race();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule